// File: doc/BRIEF.md
# Overwriting IQ Capture Buffer with Live Bypass

This block sits in a receive baseband path between the decimation stages and the demodulation chain. It records a stream of complex IQ samples into a circular store of `DEPTH` entries. Each sample is one 32-bit word, with the signed 16-bit I component in bits 31:16 and the signed 16-bit Q component in bits 15:0. While the receiver searches for a frame, writing runs with reading stopped and the output shows the live input. If the store fills, each new sample replaces the oldest one, so the store always holds the most recent `DEPTH` samples.

When the frame start has been found, the output select moves to the store and reading starts. The stored samples then drain in arrival order, and the samples that keep arriving are appended behind them. The result is one continuous stream with no gap and no repeated sample. Reads run in a single clock domain at a selectable multiple (1, 2, 4 or 8) of the input sample rate, so the backlog drains faster than new samples arrive. A wideband mode limits the multiple to 2. When the global enable is low, the block acts as a plain pipeline from input to output.

Top module: `iq_capture_buf`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are 0 and the store is empty. A read request made before any write produces no output.
- R2: While `en` is 0, every input sample appears on the output two clock edges later, whatever `sel_buf`, `wr_en` and `rd_en` are set to. Nothing is written to the store, so a later read with `en` high produces no output.
- R3: With `en` high and `sel_buf` 0, each sample with `in_valid` set appears on `out_data` two edges later with `out_valid` set. The 32-bit word, with I in bits 31:16 and Q in bits 15:0, passes unchanged. This holds whether or not writing is on.
- R4: With `en` high and `sel_buf` 1, each read from the store produces exactly one output word two edges later. Words leave in the order they were written.
- R5: A write to a full store with no read in the same cycle drops the oldest entry. After more than `DEPTH` writes, the store holds exactly the last `DEPTH` samples.
- R6: `ovf_flag` rises when a full store drops a sample while `rd_en` is 0. It stays set until a cycle with `ovf_clr` high. Filling the store to exactly `DEPTH` entries does not set it.
- R7: `rate_code` values 0, 1, 2 and 3 allow 1, 2, 4 and 8 reads per input strobe. Each `in_valid` with `en` high restores that read allowance. Reads take place only while `rd_en` is 1.
- R8: With `wide_mode` set, `rate_code` 2 or 3 behaves as 1 (two reads per strobe). Codes 0 and 1 keep their normal meaning.
- R9: A read request while the store is empty stalls and produces no output word.
- R10: Suppose writing runs, then `sel_buf` moves to 1 and reading starts while writing continues. The output then carries every sample written since the store was last empty, in order, with no duplicate and no omission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write side and the read side |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; when low, input goes straight to output |
| wr_en | input | 1 | Store incoming samples |
| rd_en | input | 1 | Allow reads from the store |
| sel_buf | input | 1 | Output select: 0 = live input, 1 = store read stream |
| rate_code | input | 2 | Read multiple: 0 = 1x, 1 = 2x, 2 = 4x, 3 = 8x |
| wide_mode | input | 1 | Wideband mode; limits the read multiple to 2x |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 32 | Input sample, I in bits 31:16, Q in bits 15:0 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 32 | Output sample, same packing as the input |
| ovf_flag | output | 1 | Sticky flag: a sample was dropped while reading was off |

## Verification
Errors in the write pointer, read pointer or occupancy count show up at the ports as a wrong first word when the store is drained, or as the wrong number of words. For example, a bad drop-oldest step makes the first replayed word a sample other than number `DEPTH` before the newest one. These errors become visible within two edges of the first read after the mistake. A wrong read-allowance counter changes the number of words that follow each input strobe, which the bench can count within one input period. Skew between the live path and the store path shows up as a misordered, repeated or missing word at the moment the output select changes.

// File: rtl/iq_buf_pkg.sv
package iq_buf_pkg;
  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  // wideband mode allows only the two slow multiples
  function automatic logic [1:0] clamp_rate(input logic [1:0] code, input logic wide);
    if (wide && code[1]) return RATE_X2;
    return code;
  endfunction

  // reads allowed per input strobe
  function automatic logic [3:0] reads_per_tick(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/iq_buf_store.sv
module iq_buf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_req,
  input  logic          rd_on,
  input  logic          ovf_clr,
  output logic          rd_fire,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  output logic          ovf_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, drop;

  assign full    = (count == FULLC);
  assign rd_fire = rd_req && (count != '0);
  assign drop    = wr && full && !rd_fire;

  // block RAM style: no reset, read-first on a shared address
  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
    if (rd_fire) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_vld   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      rd_vld <= rd_fire;
      if (wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_fire || drop) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr, rd_fire})
        2'b10:   if (!full) count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop && !rd_on) ovf_flag <= 1'b1;
      else if (ovf_clr)   ovf_flag <= 1'b0;
    end
  end

  // R5
  full_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd_fire) |=> (count == FULLC));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr) |=> (!rd_vld && count == '0));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R6
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !(wr && full)) |=> !ovf_flag);
endmodule

// File: rtl/iq_buf_rate.sv
module iq_buf_rate
  import iq_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] code,
  input  logic       rd_on,
  input  logic       rd_fire,
  output logic       rd_req
);
  logic [3:0] credits;
  logic [3:0] n_reads;

  assign n_reads = reads_per_tick(code);
  assign rd_req  = rd_on && (credits != '0);

  always_ff @(posedge clk) begin
    if (rst) credits <= '0;
    else if (tick) credits <= n_reads - (rd_fire ? 4'd1 : 4'd0);
    else if (rd_fire) credits <= credits - 4'd1;
  end

  // R7
  credit_limit_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (credits <= $past(n_reads)));

  // R7
  credit_spend_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rd_fire) |=> $stable(credits));
endmodule

// File: rtl/iq_buf_outmux.sv
module iq_buf_outmux #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          live_v,
  input  logic [DW-1:0] live_d,
  input  logic          use_buf,
  input  logic          buf_v,
  input  logic [DW-1:0] buf_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  logic          live_v_q, use_buf_q;
  logic [DW-1:0] live_d_q;

  // live path gets one stage to match the store's read register
  always_ff @(posedge clk) begin
    if (rst) begin
      live_v_q  <= 1'b0;
      live_d_q  <= '0;
      use_buf_q <= 1'b0;
      out_v     <= 1'b0;
      out_d     <= '0;
    end else begin
      live_v_q  <= live_v;
      live_d_q  <= live_d;
      use_buf_q <= use_buf;
      out_v     <= use_buf_q ? buf_v : live_v_q;
      out_d     <= use_buf_q ? buf_d : live_d_q;
    end
  end

  // R4
  buf_path_chk: assert property (@(posedge clk) disable iff (rst)
    (use_buf_q && buf_v) |=> (out_v && out_d == $past(buf_d)));
endmodule

// File: rtl/iq_capture_buf.sv
module iq_capture_buf
  import iq_buf_pkg::*;
#(
  parameter int IQ_W  = 16,
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel_buf,
  input  logic [1:0]        rate_code,
  input  logic              wide_mode,
  input  logic              ovf_clr,
  input  logic              in_valid,
  input  logic [2*IQ_W-1:0] in_data,
  output logic              out_valid,
  output logic [2*IQ_W-1:0] out_data,
  output logic              ovf_flag
);
  localparam int DW = 2 * IQ_W;

  logic          tick, wr, rd_on, rd_req, rd_fire, rd_vld;
  logic [1:0]    eff_code;
  logic [DW-1:0] rd_data;
  logic [1:0]    age;

  assign tick     = en && in_valid;
  assign wr       = tick && wr_en;
  assign rd_on    = en && rd_en;
  assign eff_code = clamp_rate(rate_code, wide_mode);

  iq_buf_rate u_rate (
    .clk(clk), .rst(rst), .tick(tick), .code(eff_code),
    .rd_on(rd_on), .rd_fire(rd_fire), .rd_req(rd_req)
  );

  iq_buf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr(wr), .wdata(in_data),
    .rd_req(rd_req), .rd_on(rd_en), .ovf_clr(ovf_clr),
    .rd_fire(rd_fire), .rd_vld(rd_vld), .rd_data(rd_data),
    .ovf_flag(ovf_flag)
  );

  iq_buf_outmux #(.DW(DW)) u_mux (
    .clk(clk), .rst(rst), .live_v(in_valid), .live_d(in_data),
    .use_buf(en && sel_buf), .buf_v(rd_vld), .buf_d(rd_data),
    .out_v(out_valid), .out_d(out_data)
  );

  // cycles since reset, for checks that look two cycles back
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R8
  wide_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    wide_mode |-> (eff_code <= RATE_X2));

  // R2
  disabled_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(en, 2) && !$past(en, 1) && $past(in_valid, 2))
      |-> (out_valid && out_data == $past(in_data, 2)));

  // R3
  live_path_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(sel_buf, 2) && $past(in_valid, 2))
      |-> (out_valid && out_data == $past(in_data, 2)));
endmodule

// File: tb/tb_iq_capture_buf.sv
`timescale 1ns/1ps
module tb_iq_capture_buf;
  localparam int DEPTH = 2048;
  localparam int ROWS  = 8;
  // row: [7:6] rate_code, [5] wide_mode, [3:0] expected reads per strobe
  localparam logic [7:0] TBL [ROWS] = '{8'h01, 8'h42, 8'h84, 8'hC8,
                                        8'h21, 8'h62, 8'hA2, 8'hE2};

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, wr_en = 0, rd_en = 0, sel_buf = 0, wide_mode = 0, ovf_clr = 0, in_valid = 0;
  logic [1:0] rate_code = 0;
  logic [31:0] in_data = 0;
  logic out_valid, ovf_flag;
  logic [31:0] out_data;

  int checks = 0, errors = 0, ncap = 0;
  logic [31:0] cap [4096];
  bit done = 0;

  always #2.5 clk = ~clk;

  iq_capture_buf dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .rd_en(rd_en), .sel_buf(sel_buf),
    .rate_code(rate_code), .wide_mode(wide_mode), .ovf_clr(ovf_clr),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .ovf_flag(ovf_flag)
  );

  always @(negedge clk) if (!rst && out_valid && ncap < 4096) begin
    cap[ncap] = out_data;
    ncap++;
  end

  function automatic logic [31:0] smp(input int k);
    return {k[15:0], ~k[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int k);
    in_valid = 1; in_data = smp(k);
    idle(1);
    in_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1; idle(3); rst = 0; idle(1); ncap = 0;
  endtask

  // count captured words that differ from smp(first + i)
  function automatic int seq_bad(input int n, input int first);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== smp(first + i)) bad++;
    return bad;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    idle(4);
    rst = 0; idle(1);
    // R1 reset state and empty store
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(ovf_flag == 0, "R1 ovf_flag", ovf_flag, 0);
    en = 1; rd_en = 1; sel_buf = 1; rate_code = 2'd3;
    ncap = 0; send(5); idle(12);
    check(ncap == 0, "R1 no data after reset", ncap, 0);
    // R9 empty stall
    send(6); idle(12);
    check(ncap == 0, "R9 empty read stalls", ncap, 0);

    // table of read multiples: R7, R8, R4
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      rate_code = TBL[r][7:6]; wide_mode = TBL[r][5];
      en = 1; wr_en = 1; rd_en = 0; sel_buf = 1;
      for (int k = 0; k < 40; k++) send(k);
      idle(2);
      check(ncap == 0, "R4 nothing read while rd_en low", ncap, 0);
      ncap = 0; wr_en = 0; rd_en = 1;
      idle(16);
      for (int p = 0; p < 3; p++) begin send(999); idle(15); end
      idle(8);
      n = 4 * int'(TBL[r][3:0]);
      check(ncap == n, TBL[r][5] ? "R8 clamped reads" : "R7 reads per strobe", ncap, n);
      check(seq_bad(ncap, 0) == 0, "R4 read order", seq_bad(ncap, 0), 0);
    end
    wide_mode = 0;

    // R2 disabled bypass
    do_reset();
    en = 0; wr_en = 1; rd_en = 1; sel_buf = 1;
    for (int k = 100; k < 105; k++) send(k);
    idle(3);
    check(ncap == 5, "R2 bypass count", ncap, 5);
    check(seq_bad(5, 100) == 0, "R2 bypass data", seq_bad(5, 100), 0);
    ncap = 0; en = 1; wr_en = 0; rate_code = 2'd3;
    send(0); idle(12);
    check(ncap == 0, "R2 no writes while disabled", ncap, 0);

    // R3 live path and latency
    do_reset();
    en = 1; wr_en = 1; rd_en = 0; sel_buf = 0;
    in_valid = 1; in_data = 32'h8001_7FFE; idle(1); in_valid = 0;
    check(out_valid == 0, "R3 not early", out_valid, 0);
    idle(1);
    check(out_valid == 1 && out_data == 32'h8001_7FFE, "R3 two-edge latency", out_data, 32'h8001_7FFE);
    idle(2); ncap = 0;
    for (int k = 0; k < 10; k++) begin send(k); idle(1); end
    idle(3);
    check(ncap == 10 && seq_bad(10, 0) == 0, "R3 live stream", ncap, 10);

    // R5 / R6 overwrite
    do_reset();
    en = 1; wr_en = 1; rd_en = 0; sel_buf = 0; rate_code = 2'd3;
    for (int k = 0; k < DEPTH; k++) send(k);
    idle(1);
    check(ovf_flag == 0, "R6 exactly full no flag", ovf_flag, 0);
    for (int k = DEPTH; k < DEPTH + 5; k++) send(k);
    idle(1);
    check(ovf_flag == 1, "R6 flag on overwrite", ovf_flag, 1);
    idle(3);
    check(ovf_flag == 1, "R6 flag sticky", ovf_flag, 1);
    ovf_clr = 1; idle(1); ovf_clr = 0; idle(1);
    check(ovf_flag == 0, "R6 flag cleared", ovf_flag, 0);
    idle(3); ncap = 0;
    wr_en = 0; rd_en = 1; sel_buf = 1;
    for (int p = 0; p < 270; p++) begin send(0); idle(9); end
    idle(5);
    check(ncap == DEPTH, "R5 stored count", ncap, DEPTH);
    check(cap[0] == smp(5), "R5 oldest kept", cap[0], smp(5));
    check(cap[DEPTH-1] == smp(DEPTH + 4), "R5 newest kept", cap[DEPTH-1], smp(DEPTH + 4));
    check(seq_bad(DEPTH, 5) == 0, "R5 order", seq_bad(DEPTH, 5), 0);

    // R10 seamless switch
    do_reset();
    en = 1; wr_en = 1; rd_en = 0; sel_buf = 0; rate_code = 2'd1;
    for (int k = 0; k < 20; k++) begin send(k); idle(3); end
    check(ncap == 20 && seq_bad(20, 0) == 0, "R3 live during capture", ncap, 20);
    ncap = 0; sel_buf = 1; rd_en = 1;
    for (int k = 20; k < 60; k++) begin send(k); idle(3); end
    idle(10);
    check(ncap == 60, "R10 replay count", ncap, 60);
    check(seq_bad(60, 0) == 0, "R10 replay continuity", seq_bad(60, 0), 0);

    finish_run();
  end
endmodule